// File: doc/BRIEF.md
# Two-Port Mailbox Exchange with Interrupt Flags

This block lets two processors signal each other through small register mailboxes. Each side owns a set of outgoing mailboxes. Writing one of them raises a flag toward the other side. The other side reads the word back through its incoming window, and that read clears the flag. Each side also holds an interrupt mask. Its active-low interrupt line is pulled low while any incoming flag has a set mask bit. With the default parameters there are four 16-bit mailboxes in each direction.

A port reaches the mailbox space only while its mailbox-select input is low. The same low address bits address the main memory when that input is high, and the memory is outside this block. Every access is sampled on the rising clock edge. An access is ignored unless chip select is high and at least one byte enable is set. A write needs the write strobe high. A read needs the write strobe low and the output enable high.

Per-port offsets:
- 0 to NUM_BOX-1: own outgoing mailboxes, read and write.
- NUM_BOX to 2*NUM_BOX-1: incoming mailboxes, read only. A read clears the matching flag.
- 2*NUM_BOX: the interrupt mask.
- 2*NUM_BOX+1: incoming flag status, read only.

Each port runs a two-state read-output machine with states S_IDLE and S_SHOW:
- T_LAUNCH (S_IDLE to S_SHOW): a read is sampled.
- T_AGAIN (S_SHOW to S_SHOW): a further read is sampled.
- T_DROP (S_SHOW to S_IDLE): a cycle passes with no read.
- T_WAIT (S_IDLE to S_IDLE): the port stays idle with no read.

Top module: `mbx_xchg`

## Requirements
- R1: After reset, both read-data outputs are zero and both interrupt outputs are high. All mailboxes, flags and mask bits are zero, so the mask and status offsets and every mailbox read back as zero.
- R2: An access takes effect only when chip select is 1, mailbox select is 0 and the byte-enable field is nonzero. Otherwise the access changes no mailbox, flag or mask, and it returns no data.
- R3: A write to offset i (0 to 3) stores the enabled bytes into outgoing mailbox i and sets flag i toward the other port. Byte-enable bit 0 covers data bits 7:0 and bit 1 covers bits 15:8.
- R4: A read at offset 4+i returns the other port's outgoing mailbox i and clears flag i of that direction. A read at offset i returns the port's own outgoing mailbox and leaves the flags unchanged.
- R5: Read data appears on the read-data output in the cycle after the sampling edge, with the bytes that were not enabled forced to zero. A read needs the write strobe at 0 and the output enable at 1. In any cycle with no read at the previous edge, read data is zero.
- R6: Offset 8 holds the mask. A write with byte-enable bit 0 set loads data bits 3:0 into the mask. A write without that bit leaves the mask unchanged. A read returns the mask in bits 3:0 and zeros above.
- R7: Offset 9 returns the incoming flags in bits 3:0, bit i for mailbox i. Writes to offset 9 are ignored.
- R8: A port's interrupt output is 0 exactly when some incoming flag is 1 and its mask bit is 1. A mask bit of 0 blocks its flag.
- R9: If a set and a clear of the same flag meet at one edge, the flag ends up set. The read at that edge returns the mailbox value from before the edge.
- R10: Writes to offsets 4 to 7 and to unmapped offsets (10 to 63) change nothing. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_cs | input | 1 | Port A chip select, active high |
| a_wr | input | 1 | Port A write strobe (1 write, 0 read) |
| a_oe | input | 1 | Port A output enable, active high |
| a_be | input | NBYTE | Port A byte enables |
| a_addr | input | ADDR_W | Port A address, low bits |
| a_wdata | input | DATA_W | Port A write data |
| a_mbx_n | input | 1 | Port A mailbox select, active low |
| a_rdata | output | DATA_W | Port A read data |
| a_irq_n | output | 1 | Port A interrupt, active low |
| b_cs | input | 1 | Port B chip select, active high |
| b_wr | input | 1 | Port B write strobe (1 write, 0 read) |
| b_oe | input | 1 | Port B output enable, active high |
| b_be | input | NBYTE | Port B byte enables |
| b_addr | input | ADDR_W | Port B address, low bits |
| b_wdata | input | DATA_W | Port B write data |
| b_mbx_n | input | 1 | Port B mailbox select, active low |
| b_rdata | output | DATA_W | Port B read data |
| b_irq_n | output | 1 | Port B interrupt, active low |

## Verification
The bench builds the block with its defaults: four mailboxes per direction, 16-bit words and a 6-bit address. These values make the whole offset space reachable. That covers both mailbox windows, the mask and status words, and unmapped offsets up to 63. Two byte lanes allow partial writes and lane-masked reads to be told apart. Four flags per side let a single mask bit be shown to block one flag while passing another.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Decoded meaning of one port's access in the current cycle
    typedef enum logic [2:0] {
        K_NONE    = 3'd0,
        K_WR_OUT  = 3'd1,
        K_WR_MASK = 3'd2,
        K_RD_OUT  = 3'd3,
        K_RD_IN   = 3'd4,
        K_RD_MASK = 3'd5,
        K_RD_STAT = 3'd6,
        K_RD_NULL = 3'd7
    } acc_kind_e;

    // Read-output machine of one port
    typedef enum logic {
        S_IDLE = 1'b0,
        S_SHOW = 1'b1
    } rd_state_e;

    function automatic logic is_read(input acc_kind_e k);
        return (k == K_RD_OUT) || (k == K_RD_IN) || (k == K_RD_MASK)
            || (k == K_RD_STAT) || (k == K_RD_NULL);
    endfunction

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
    import mbx_pkg::*;
#(
    parameter int NUM_BOX = 4,
    parameter int ADDR_W  = 6,
    parameter int NBYTE   = 2,
    parameter int IDX_W   = $clog2(NUM_BOX)
) (
    input  logic              cs,
    input  logic              wr,
    input  logic              oe,
    input  logic [NBYTE-1:0]  be,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mbx_n,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] IN_LO   = ADDR_W'(NUM_BOX);
    localparam logic [ADDR_W-1:0] IN_HI   = ADDR_W'(2 * NUM_BOX);
    localparam logic [ADDR_W-1:0] OFF_MSK = ADDR_W'(2 * NUM_BOX);
    localparam logic [ADDR_W-1:0] OFF_STA = ADDR_W'(2 * NUM_BOX + 1);

    logic              hit;
    logic [ADDR_W-1:0] rel;

    assign hit = cs && !mbx_n && (be != '0);
    assign rel = (addr >= IN_LO && addr < IN_HI) ? (addr - IN_LO) : addr;
    assign idx = rel[IDX_W-1:0];

    always_comb begin
        kind = K_NONE;
        if (hit) begin
            if (wr) begin
                if (addr < IN_LO)         kind = K_WR_OUT;
                else if (addr == OFF_MSK) kind = K_WR_MASK;
            end else if (oe) begin
                if (addr < IN_LO)         kind = K_RD_OUT;
                else if (addr < IN_HI)    kind = K_RD_IN;
                else if (addr == OFF_MSK) kind = K_RD_MASK;
                else if (addr == OFF_STA) kind = K_RD_STAT;
                else                      kind = K_RD_NULL;
            end
        end
    end
endmodule

// File: rtl/mbx_dir.sv
module mbx_dir #(
    parameter int NUM_BOX = 4,
    parameter int DATA_W  = 16,
    parameter int NBYTE   = DATA_W / 8,
    parameter int IDX_W   = $clog2(NUM_BOX)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            set_en,
    input  logic [IDX_W-1:0]                set_idx,
    input  logic [NBYTE-1:0]                set_be,
    input  logic [DATA_W-1:0]               set_data,
    input  logic                            clr_en,
    input  logic [IDX_W-1:0]                clr_idx,
    output logic [NUM_BOX-1:0][DATA_W-1:0]  box,
    output logic [NUM_BOX-1:0]              flag
);
    for (genvar g = 0; g < NUM_BOX; g++) begin : g_box
        logic [DATA_W-1:0] word_q;
        logic              flag_q;
        logic              set_me;
        logic              clr_me;

        assign set_me = set_en && (set_idx == IDX_W'(g));
        assign clr_me = clr_en && (clr_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (set_me) begin
                for (int k = 0; k < NBYTE; k++) begin
                    if (set_be[k]) word_q[k*8 +: 8] <= set_data[k*8 +: 8];
                end
            end
        end

        // a set at the same edge as a clear takes priority
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flag_q <= 1'b0;
            else if (set_me) flag_q <= 1'b1;
            else if (clr_me) flag_q <= 1'b0;
        end

        assign box[g]  = word_q;
        assign flag[g] = flag_q;
    end
endmodule

// File: rtl/mbx_port_ctl.sv
module mbx_port_ctl
    import mbx_pkg::*;
#(
    parameter int NUM_BOX = 4,
    parameter int DATA_W  = 16,
    parameter int NBYTE   = DATA_W / 8,
    parameter int IDX_W   = $clog2(NUM_BOX)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  acc_kind_e                       kind,
    input  logic [IDX_W-1:0]                idx,
    input  logic [NBYTE-1:0]                be,
    input  logic [DATA_W-1:0]               wdata,
    input  logic [NUM_BOX-1:0][DATA_W-1:0]  out_box,
    input  logic [NUM_BOX-1:0][DATA_W-1:0]  in_box,
    input  logic [NUM_BOX-1:0]              in_flag,
    output logic [NUM_BOX-1:0]              mask,
    output logic [DATA_W-1:0]               rdata,
    output logic                            irq_n
);
    rd_state_e         st_q, st_nx;
    logic [DATA_W-1:0] pick, lane, hold_q;
    logic [NUM_BOX-1:0] mask_q;
    logic              rd_now;

    assign rd_now = is_read(kind);

    // word chosen by the access, before lane masking
    always_comb begin
        unique case (kind)
            K_RD_OUT:  pick = out_box[idx];
            K_RD_IN:   pick = in_box[idx];
            K_RD_MASK: pick = DATA_W'(mask_q);
            K_RD_STAT: pick = DATA_W'(in_flag);
            default:   pick = '0;
        endcase
    end

    always_comb begin
        for (int k = 0; k < NBYTE; k++) begin
            lane[k*8 +: 8] = be[k] ? pick[k*8 +: 8] : 8'h00;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_nx;
    end

    // transitions: T_LAUNCH / T_WAIT from S_IDLE, T_AGAIN / T_DROP from S_SHOW
    always_comb begin
        unique case (st_q)
            S_IDLE:  st_nx = rd_now ? S_SHOW : S_IDLE;
            S_SHOW:  st_nx = rd_now ? S_SHOW : S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hold_q <= '0;
        else if (rd_now) hold_q <= lane;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          mask_q <= '0;
        else if (kind == K_WR_MASK && be[0]) mask_q <= wdata[NUM_BOX-1:0];
    end

    // outputs
    always_comb begin
        unique case (st_q)
            S_SHOW:  rdata = hold_q;
            default: rdata = '0;
        endcase
        irq_n = ~|(in_flag & mask_q);
        mask  = mask_q;
    end
endmodule

// File: rtl/mbx_xchg.sv
module mbx_xchg
    import mbx_pkg::*;
#(
    parameter int NUM_BOX = 4,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 6,
    localparam int NBYTE  = DATA_W / 8,
    localparam int IDX_W  = $clog2(NUM_BOX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_cs,
    input  logic              a_wr,
    input  logic              a_oe,
    input  logic [NBYTE-1:0]  a_be,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_mbx_n,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq_n,
    input  logic              b_cs,
    input  logic              b_wr,
    input  logic              b_oe,
    input  logic [NBYTE-1:0]  b_be,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_mbx_n,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq_n
);
    acc_kind_e                     a_kind, b_kind;
    logic [IDX_W-1:0]              a_idx, b_idx;
    logic [NUM_BOX-1:0][DATA_W-1:0] ab_box, ba_box;
    logic [NUM_BOX-1:0]            ab_flag, ba_flag;
    logic [NUM_BOX-1:0]            mask_a, mask_b;

    mbx_port_dec #(.NUM_BOX(NUM_BOX), .ADDR_W(ADDR_W), .NBYTE(NBYTE), .IDX_W(IDX_W)) u_dec_a (
        .cs(a_cs), .wr(a_wr), .oe(a_oe), .be(a_be), .addr(a_addr),
        .mbx_n(a_mbx_n), .kind(a_kind), .idx(a_idx)
    );

    mbx_port_dec #(.NUM_BOX(NUM_BOX), .ADDR_W(ADDR_W), .NBYTE(NBYTE), .IDX_W(IDX_W)) u_dec_b (
        .cs(b_cs), .wr(b_wr), .oe(b_oe), .be(b_be), .addr(b_addr),
        .mbx_n(b_mbx_n), .kind(b_kind), .idx(b_idx)
    );

    // A to B direction: A sets, B clears
    mbx_dir #(.NUM_BOX(NUM_BOX), .DATA_W(DATA_W), .NBYTE(NBYTE), .IDX_W(IDX_W)) u_ab (
        .clk(clk), .rst_n(rst_n),
        .set_en(a_kind == K_WR_OUT), .set_idx(a_idx), .set_be(a_be), .set_data(a_wdata),
        .clr_en(b_kind == K_RD_IN), .clr_idx(b_idx),
        .box(ab_box), .flag(ab_flag)
    );

    // B to A direction: B sets, A clears
    mbx_dir #(.NUM_BOX(NUM_BOX), .DATA_W(DATA_W), .NBYTE(NBYTE), .IDX_W(IDX_W)) u_ba (
        .clk(clk), .rst_n(rst_n),
        .set_en(b_kind == K_WR_OUT), .set_idx(b_idx), .set_be(b_be), .set_data(b_wdata),
        .clr_en(a_kind == K_RD_IN), .clr_idx(a_idx),
        .box(ba_box), .flag(ba_flag)
    );

    mbx_port_ctl #(.NUM_BOX(NUM_BOX), .DATA_W(DATA_W), .NBYTE(NBYTE), .IDX_W(IDX_W)) u_ctl_a (
        .clk(clk), .rst_n(rst_n), .kind(a_kind), .idx(a_idx), .be(a_be), .wdata(a_wdata),
        .out_box(ab_box), .in_box(ba_box), .in_flag(ba_flag),
        .mask(mask_a), .rdata(a_rdata), .irq_n(a_irq_n)
    );

    mbx_port_ctl #(.NUM_BOX(NUM_BOX), .DATA_W(DATA_W), .NBYTE(NBYTE), .IDX_W(IDX_W)) u_ctl_b (
        .clk(clk), .rst_n(rst_n), .kind(b_kind), .idx(b_idx), .be(b_be), .wdata(b_wdata),
        .out_box(ba_box), .in_box(ab_box), .in_flag(ab_flag),
        .mask(mask_b), .rdata(b_rdata), .irq_n(b_irq_n)
    );
endmodule

// File: rtl/mbx_xchg_chk.sv
module mbx_xchg_chk
    import mbx_pkg::*;
#(
    parameter int NUM_BOX = 4,
    parameter int DATA_W  = 16,
    parameter int IDX_W   = $clog2(NUM_BOX)
) (
    input logic                            clk,
    input logic                            rst_n,
    input acc_kind_e                       a_kind,
    input acc_kind_e                       b_kind,
    input logic [IDX_W-1:0]                a_idx,
    input logic [IDX_W-1:0]                b_idx,
    input logic [NUM_BOX-1:0]              ab_flag,
    input logic [NUM_BOX-1:0]              ba_flag,
    input logic [NUM_BOX-1:0][DATA_W-1:0]  ab_box,
    input logic [NUM_BOX-1:0]              mask_a,
    input logic [DATA_W-1:0]               a_rdata,
    input logic [DATA_W-1:0]               b_rdata
);
    logic a_set, b_set, a_clr, b_clr, a_rd, b_rd;
    assign a_set = (a_kind == K_WR_OUT);
    assign b_set = (b_kind == K_WR_OUT);
    assign a_clr = (a_kind == K_RD_IN);
    assign b_clr = (b_kind == K_RD_IN);
    assign a_rd  = is_read(a_kind);
    assign b_rd  = is_read(b_kind);

    // R3: a mailbox write raises the flag toward the other port
    p_set_ab_r3: assert property (@(posedge clk) disable iff (!rst_n)
        a_set |=> ab_flag[$past(a_idx)]);
    p_set_ba_r3: assert property (@(posedge clk) disable iff (!rst_n)
        b_set |=> ba_flag[$past(b_idx)]);

    // R4: an incoming read with no competing set clears the flag
    p_clr_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (b_clr && !(a_set && a_idx == b_idx)) |=> !ab_flag[$past(b_idx)]);

    // R9: the set wins over a clear at the same edge
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (b_clr && a_set && a_idx == b_idx) |=> ab_flag[$past(b_idx)]);

    // R10: with neither a set nor a clear the flags hold
    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_set && !b_clr) |=> $stable(ab_flag));
    p_box_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !a_set |=> $stable(ab_box));

    // R5: no read at the previous edge means zero read data
    p_rd_zero_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !a_rd |=> (a_rdata == '0));
    p_rd_zero_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !b_rd |=> (b_rdata == '0));

    // R6: the mask changes only through a mask write
    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_kind != K_WR_MASK) |=> $stable(mask_a));
endmodule

bind mbx_xchg mbx_xchg_chk #(.NUM_BOX(NUM_BOX), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .a_kind(a_kind), .b_kind(b_kind),
    .a_idx(a_idx), .b_idx(b_idx), .ab_flag(ab_flag), .ba_flag(ba_flag),
    .ab_box(ab_box), .mask_a(mask_a), .a_rdata(a_rdata), .b_rdata(b_rdata)
);

// File: tb/sim_mbx_xchg.sv
`timescale 1ns/1ps
module sim_mbx_xchg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_cs, a_wr, a_oe, a_mbx_n, b_cs, b_wr, b_oe, b_mbx_n;
    logic [1:0]  a_be, b_be;
    logic [5:0]  a_addr, b_addr;
    logic [15:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic        a_irq_n, b_irq_n;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        bit          p;
        logic [15:0] v;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    mbx_xchg u0 (
        .clk(clk), .rst_n(rst_n),
        .a_cs(a_cs), .a_wr(a_wr), .a_oe(a_oe), .a_be(a_be), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_mbx_n(a_mbx_n), .a_rdata(a_rdata), .a_irq_n(a_irq_n),
        .b_cs(b_cs), .b_wr(b_wr), .b_oe(b_oe), .b_be(b_be), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_mbx_n(b_mbx_n), .b_rdata(b_rdata), .b_irq_n(b_irq_n)
    );

    task automatic chk(bit ok, string tag, logic [15:0] got, logic [15:0] want);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%h want=%h", tag, got, want);
        end
    endtask

    task automatic clr();
        a_cs = 0; a_wr = 0; a_oe = 0; a_be = 0; a_addr = 0; a_wdata = 0; a_mbx_n = 1;
        b_cs = 0; b_wr = 0; b_oe = 0; b_be = 0; b_addr = 0; b_wdata = 0; b_mbx_n = 1;
    endtask

    task automatic put(bit p, logic cs, logic w, logic oe, logic [1:0] be,
                       int ad, logic [15:0] wd, logic seln);
        if (!p) begin
            a_cs = cs; a_wr = w; a_oe = oe; a_be = be; a_addr = 6'(ad); a_wdata = wd; a_mbx_n = seln;
        end else begin
            b_cs = cs; b_wr = w; b_oe = oe; b_be = be; b_addr = 6'(ad); b_wdata = wd; b_mbx_n = seln;
        end
    endtask

    task automatic push(bit p, logic [15:0] v, string tag);
        exp_t e;
        e.p = p; e.v = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wr(bit p, int ad, logic [15:0] d, logic [1:0] be = 2'b11);
        @(negedge clk); clr();
        put(p, 1, 1, 0, be, ad, d, 0);
    endtask

    task automatic rd(bit p, int ad, logic [15:0] want, string tag, logic [1:0] be = 2'b11);
        @(negedge clk); clr();
        put(p, 1, 0, 1, be, ad, 16'h0, 0);
        push(p, want, tag);
    endtask

    task automatic irq(bit p, logic want, string tag);
        @(negedge clk); clr();
        chk((p ? b_irq_n : a_irq_n) == want, tag, 16'(p ? b_irq_n : a_irq_n), 16'(want));
    endtask

    // monitor: compare read data just after the edge that follows each request
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                logic [15:0] got;
                e = exp_q.pop_front();
                got = e.p ? b_rdata : a_rdata;
                chk(got === e.v, e.tag, got, e.v);
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog got=%h want=%h", 16'h0, 16'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clr();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(a_rdata == 0 && b_rdata == 0, "R1 rdata after reset", {a_rdata[7:0], b_rdata[7:0]}, 16'h0);
        chk(a_irq_n && b_irq_n, "R1 irq after reset", 16'({a_irq_n, b_irq_n}), 16'h3);
        rd(0, 9, 16'h0000, "R1 status zero");
        rd(0, 8, 16'h0000, "R1 mask zero");
        rd(1, 4, 16'h0000, "R1 mailbox zero");

        // R8: mask zero blocks, R7 status
        wr(0, 0, 16'h1234);
        irq(1, 1'b1, "R8 mask zero blocks");
        rd(1, 9, 16'h0001, "R7 status bit0");
        wr(1, 8, 16'h000F, 2'b01);
        irq(1, 1'b0, "R8 irq asserted");
        rd(1, 8, 16'h000F, "R6 mask readback");

        // R4: incoming read returns and clears
        rd(1, 4, 16'h1234, "R4 incoming data");
        irq(1, 1'b1, "R4 irq released");
        rd(1, 9, 16'h0000, "R4 flag cleared");

        // R3 partial write, R5 lane-masked read
        wr(0, 1, 16'hAAAA);
        wr(0, 1, 16'h55BB, 2'b01);
        rd(1, 5, 16'hAABB, "R3 byte merge");
        rd(1, 5, 16'hAA00, "R5 lane mask", 2'b10);

        // R4 own read keeps flag
        wr(0, 2, 16'h0F0F);
        rd(0, 2, 16'h0F0F, "R4 own readback");
        rd(1, 9, 16'h0004, "R4 own read keeps flag");
        rd(1, 6, 16'h0F0F, "R4 incoming box2");

        // R2 gating
        @(negedge clk); clr(); put(0, 0, 1, 0, 2'b11, 3, 16'h1111, 0);
        rd(1, 9, 16'h0000, "R2 cs low");
        @(negedge clk); clr(); put(0, 1, 1, 0, 2'b11, 3, 16'h1111, 1);
        rd(1, 9, 16'h0000, "R2 select high");
        @(negedge clk); clr(); put(0, 1, 1, 0, 2'b00, 3, 16'h1111, 0);
        rd(1, 9, 16'h0000, "R2 no byte enable");
        rd(1, 7, 16'h0000, "R2 box3 untouched");
        @(negedge clk); clr(); put(0, 1, 0, 0, 2'b11, 0, 16'h0, 0);
        push(0, 16'h0000, "R5 oe low no data");
        @(negedge clk); clr(); put(0, 0, 0, 1, 2'b11, 0, 16'h0, 0);
        push(0, 16'h0000, "R2 read cs low");

        // R10 ignored writes and unmapped reads
        wr(0, 5, 16'hDEAD);
        rd(1, 1, 16'h0000, "R10 incoming write ignored");
        wr(0, 9, 16'h000F);
        rd(0, 9, 16'h0000, "R10 status write ignored");
        rd(0, 12, 16'h0000, "R10 unmapped read");
        wr(0, 12, 16'hBEEF);
        rd(0, 12, 16'h0000, "R10 unmapped write");

        // R9 set wins
        wr(1, 0, 16'h7777);
        irq(0, 1'b1, "R8 port A mask zero");
        @(negedge clk); clr();
        put(1, 1, 1, 0, 2'b11, 0, 16'h8888, 0);
        put(0, 1, 0, 1, 2'b11, 4, 16'h0, 0);
        push(0, 16'h7777, "R9 read sees old word");
        rd(0, 9, 16'h0001, "R9 flag stays set");
        wr(0, 8, 16'h0001, 2'b01);
        irq(0, 1'b0, "R9 irq from kept flag");
        rd(0, 4, 16'h8888, "R9 new word");
        irq(0, 1'b1, "R4 port A cleared");

        // R8 selective mask
        wr(0, 8, 16'h0002, 2'b01);
        wr(1, 0, 16'h0101);
        irq(0, 1'b1, "R8 masked flag blocked");
        wr(1, 1, 16'h0202);
        irq(0, 1'b0, "R8 unmasked flag drives");
        rd(0, 5, 16'h0202, "R4 port A box1");
        irq(0, 1'b1, "R8 released");

        // R6 mask write without low lane
        wr(0, 8, 16'h0000, 2'b10);
        rd(0, 8, 16'h0002, "R6 high lane ignored");

        // R5 idle cycle gives zero
        @(negedge clk); clr();
        push(0, 16'h0000, "R5 idle zero");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5 queue drained", 16'(exp_q.size()), 16'h0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule